// File: doc/BRIEF.md
# Reset and Low-Power Mode Sequencer

This block decides when the core of a small 8-bit controller may run. It holds the core in reset while a delay timer counts, and it gates the CPU clock and the main oscillator for the two sleep modes. The delay timer is a one-shot that counts pulses of a slow, free-running oscillator enable (`rc_tick`). It starts on a power-good rising edge, on a watchdog timeout, or on a wake event from stop mode when the wake-delay configuration bit is set. When that bit is clear, a wake from stop produces only a single-cycle reset pulse and the timer is not used.

The core presents each opcode it is about to execute on a valid/ready stream (`op_valid`, `op_data`, `op_ready`). The block only accepts an opcode while the core is running and out of reset. `op_ready` stays low in halt, in stop and during any reset, and the core must hold the opcode until it is accepted. A sleep opcode takes effect only when the opcode accepted just before it was the pipeline-flush NOP. Halt keeps the oscillator running and ends on any pending interrupt. Stop turns off both clocks and ends only through a reset source. After every reset the core restarts at a fixed vector.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `arst_n` is low, and on the first cycles after it rises, `core_rst` is 1, `cpu_clk_en` is 0, `op_ready` is 0 and `osc_en` is 1.
- R2: `pwr_good` passes through a two-flop synchronizer. While its synchronized value is 0, `core_rst` is held at 1. A synchronized 0-to-1 edge starts the delay timer.
- R3: Once started, the timer holds `core_rst` at 1 until it has seen `POR_TERM` cycles with `rc_tick`=1. `core_rst` falls on the cycle after the last of those ticks, provided no other reset source is active.
- R4: A new trigger that arrives while the timer is counting restarts the count from zero.
- R5: A one-cycle `wdt_timeout` pulse starts the timer from any mode, and `core_rst` is 1 on the next cycle.
- R6: In run mode, accepting 0xFF followed directly by 0x7F enters halt. `cpu_clk_en` and `op_ready` go to 0 on the next cycle and `osc_en` stays 1.
- R7: In run mode, accepting 0xFF followed directly by 0x6F enters stop. `cpu_clk_en`, `op_ready` and `osc_en` all go to 0 on the next cycle.
- R8: A 0x7F or 0x6F that is not directly preceded by an accepted 0xFF is treated as an ordinary opcode, and the mode stays run.
- R9: In halt, any bit of `irq_pend` set to 1 returns the block to run on the next cycle without a reset (`core_rst` stays 0).
- R10: In stop, `irq_pend` has no effect. Stop is left only through a watchdog timeout, a synchronized power-good edge or a power-good low level, `stop_wake`, or external reset.
- R11: `stop_wake` in stop with `wake_delay_en`=1 starts the timer. With `wake_delay_en`=0 it gives exactly one cycle of `core_rst`=1 followed by run. Outside stop, `stop_wake` has no effect.
- R12: `ext_rst_n` passes through a two-flop synchronizer. While its synchronized value is 0, `core_rst` is 1 and the mode is forced to run. On release, reset ends without the delay timer.
- R13: `op_ready` is 1 exactly when the block is in run mode and out of reset. `restart_vec` is always 0x000C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| arst_n | input | 1 | Asynchronous cold reset of the sequencer, active low |
| rc_tick | input | 1 | One-cycle enable from the slow timer oscillator |
| pwr_good | input | 1 | Supply-good level, asynchronous |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| stop_wake | input | 1 | Stop-mode wake event pulse |
| wake_delay_en | input | 1 | 1: wake from stop runs the delay timer; 0: bypass |
| irq_pend | input | NIRQ | Enabled, pending interrupt requests |
| op_valid | input | 1 | Opcode stream valid |
| op_data | input | 8 | Opcode about to execute |
| op_ready | output | 1 | Opcode accepted when high together with `op_valid` |
| core_rst | output | 1 | Reset to the core, active high |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| restart_vec | output | 16 | Address the core fetches from after reset |

## Verification
The hardest state to reach from the ports is a retrigger in the middle of a count while the block is leaving stop. The timer must already be counting, and a second reset source must arrive before the terminal tick, so that the count visibly restarts. The stimulus first places the block in stop with the flush/stop opcode pair. It then wakes the block with a watchdog pulse and fires another watchdog pulse a few slow ticks later. It also repeats the stop entry with each setting of the wake-delay bit, so that the timed exit and the single-pulse exit are both seen. A behavioural model in the bench tracks remaining ticks, mode and the flush flag, and it is compared against every output on each clock.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int POR_TERM = 160
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig,
  input  logic tick,
  output logic busy
);
  localparam int CNT_W = (POR_TERM > 2) ? $clog2(POR_TERM) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_TERM - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrseq_mode.sv
module pwrseq_mode
  import pwrseq_pkg::*;
#(
  parameter int         NIRQ     = 4,
  parameter logic [7:0] OPC_NOP  = 8'hFF,
  parameter logic [7:0] OPC_HALT = 8'h7F,
  parameter logic [7:0] OPC_STOP = 8'h6F
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            force_run,
  input  logic            byp_set,
  input  logic            op_fire,
  input  logic [7:0]      opcode,
  input  logic [NIRQ-1:0] irq_pend,
  output pm_mode_e        mode,
  output logic            byp_q
);
  logic     flushed;
  pm_mode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    if (force_run) begin
      mode_nx = PM_RUN;
    end else begin
      unique case (mode)
        PM_RUN: begin
          if (op_fire && flushed && opcode == OPC_HALT) mode_nx = PM_HALT;
          else if (op_fire && flushed && opcode == OPC_STOP) mode_nx = PM_STOP;
        end
        PM_HALT: if (|irq_pend) mode_nx = PM_RUN;
        PM_STOP: mode_nx = PM_STOP;
        default: mode_nx = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode    <= PM_RUN;
      flushed <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      mode  <= mode_nx;
      byp_q <= byp_set;
      if (force_run)    flushed <= 1'b0;
      else if (op_fire) flushed <= (opcode == OPC_NOP);
    end
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int          POR_TERM    = 160,
  parameter int          NIRQ        = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] RESTART_VEC = 16'h000C
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rc_tick,
  input  logic             pwr_good,
  input  logic             ext_rst_n,
  input  logic             wdt_timeout,
  input  logic             stop_wake,
  input  logic             wake_delay_en,
  input  logic [NIRQ-1:0]  irq_pend,
  input  logic             op_valid,
  input  logic [7:0]       op_data,
  output logic             op_ready,
  output logic             core_rst,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic [VEC_W-1:0] restart_vec
);
  logic     pg_s, pg_d, er_s;
  logic     pg_rise, trig, byp_set, force_run, busy, byp_q, in_stop;
  pm_mode_e mode;

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .arst_n(arst_n), .d(pwr_good), .q(pg_s));

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_er_sync (
    .clk(clk), .arst_n(arst_n), .d(ext_rst_n), .q(er_s));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pg_d <= 1'b0;
    else         pg_d <= pg_s;
  end

  assign pg_rise   = pg_s & ~pg_d;
  assign in_stop   = (mode == PM_STOP);
  assign trig      = pg_rise | wdt_timeout | (stop_wake & in_stop & wake_delay_en);
  assign byp_set   = stop_wake & in_stop & ~wake_delay_en;
  assign force_run = trig | ~er_s | ~pg_s | byp_set;

  pwrseq_timer #(.POR_TERM(POR_TERM)) u_timer (
    .clk(clk), .arst_n(arst_n), .trig(trig), .tick(rc_tick), .busy(busy));

  pwrseq_mode #(.NIRQ(NIRQ)) u_mode (
    .clk(clk), .arst_n(arst_n), .force_run(force_run), .byp_set(byp_set),
    .op_fire(op_valid & op_ready), .opcode(op_data), .irq_pend(irq_pend),
    .mode(mode), .byp_q(byp_q));

  assign core_rst    = busy | ~er_s | ~pg_s | byp_q;
  assign cpu_clk_en  = (mode == PM_RUN) & ~core_rst;
  assign op_ready    = cpu_clk_en;
  assign osc_en      = ~in_stop;
  assign restart_vec = VEC_W'(RESTART_VEC);
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            arst_n,
  input logic            rc_tick,
  input logic            ext_rst_n,
  input logic            wdt_timeout,
  input logic            stop_wake,
  input logic [NIRQ-1:0] irq_pend,
  input logic            core_rst,
  input logic            cpu_clk_en,
  input logic            osc_en,
  input logic            busy,
  input logic            trig,
  input logic            pg_s,
  input logic            pg_rise,
  input logic            er_s
);
  // R3
  timer_needs_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && !rc_tick) |=> busy);

  // R5
  wdt_resets_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_timeout |=> core_rst);

  // R7
  stop_clk_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_en |-> !cpu_clk_en);

  // R9
  halt_irq_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (osc_en && !cpu_clk_en && !core_rst && (|irq_pend)) |=> (cpu_clk_en || core_rst));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!osc_en && !trig && !stop_wake && pg_s && !pg_rise && er_s) |=> !osc_en);

  // R12
  ext_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(ext_rst_n, 2) |-> core_rst);
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .arst_n(arst_n), .rc_tick(rc_tick), .ext_rst_n(ext_rst_n),
  .wdt_timeout(wdt_timeout), .stop_wake(stop_wake), .irq_pend(irq_pend),
  .core_rst(core_rst), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
  .busy(busy), .trig(trig), .pg_s(pg_s), .pg_rise(pg_rise), .er_s(er_s));

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
  localparam int TERM = 5;
  localparam int NI   = 4;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          rc_tick = 1'b0;
  logic          pwr_good = 1'b1;
  logic          ext_rst_n = 1'b1;
  logic          wdt_timeout = 1'b0;
  logic          stop_wake = 1'b0;
  logic          wake_delay_en = 1'b1;
  logic [NI-1:0] irq_pend = '0;
  logic          op_valid = 1'b0;
  logic [7:0]    op_data = 8'h00;
  logic          op_ready, core_rst, cpu_clk_en, osc_en;
  logic [15:0]   restart_vec;

  pwrseq_ctrl #(.POR_TERM(TERM), .NIRQ(NI)) u_pwrseq_ctrl (
    .clk(clk), .arst_n(arst_n), .rc_tick(rc_tick), .pwr_good(pwr_good),
    .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout), .stop_wake(stop_wake),
    .wake_delay_en(wake_delay_en), .irq_pend(irq_pend), .op_valid(op_valid),
    .op_data(op_data), .op_ready(op_ready), .core_rst(core_rst),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .restart_vec(restart_vec));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tick_ctr = 0;
  bit done = 0;
  string cur_req = "R1";

  // slow oscillator enable: one pulse every third clock
  always @(negedge clk) begin
    tick_ctr <= (tick_ctr == 2) ? 0 : tick_ctr + 1;
    rc_tick  <= (tick_ctr == 2);
  end

  // behavioural reference model: mode 0 run, 1 halt, 2 stop
  int m_left = TERM, m_mode = 0;
  bit m_flush = 0, m_byp = 0;
  bit m_pg[3] = '{0, 0, 0};
  bit m_er[2] = '{0, 0};

  function automatic bit model_rst();
    return (m_left > 0) || !m_er[1] || !m_pg[1] || m_byp;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_left = TERM; m_mode = 0; m_flush = 0; m_byp = 0;
      m_pg = '{0, 0, 0}; m_er = '{0, 0};
    end else begin
      bit rise, trig, byp, force_run, rdy, fire;
      rise = m_pg[1] && !m_pg[2];
      trig = rise || wdt_timeout || (stop_wake && m_mode == 2 && wake_delay_en);
      byp  = stop_wake && m_mode == 2 && !wake_delay_en;
      force_run = trig || !m_er[1] || !m_pg[1] || byp;
      rdy  = (m_mode == 0) && !model_rst();
      fire = op_valid && rdy;
      if (force_run) m_mode = 0;
      else if (m_mode == 0 && fire && m_flush && op_data == 8'h7F) m_mode = 1;
      else if (m_mode == 0 && fire && m_flush && op_data == 8'h6F) m_mode = 2;
      else if (m_mode == 1 && irq_pend != 0) m_mode = 0;
      if (force_run) m_flush = 0;
      else if (fire) m_flush = (op_data == 8'hFF);
      if (trig) m_left = TERM;
      else if (m_left > 0 && rc_tick) m_left = m_left - 1;
      m_byp = byp;
      m_pg[2] = m_pg[1]; m_pg[1] = m_pg[0]; m_pg[0] = pwr_good;
      m_er[1] = m_er[0]; m_er[0] = ext_rst_n;
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      bit r;
      r = model_rst();
      chk("core_rst", 16'(core_rst), 16'(r));
      chk("cpu_clk_en", 16'(cpu_clk_en), 16'(m_mode == 0 && !r));
      chk("osc_en", 16'(osc_en), 16'(m_mode != 2));
      chk("op_ready", 16'(op_ready), 16'(m_mode == 0 && !r));  // R13
      chk("restart_vec", restart_vec, 16'h000C);                // R13
    end
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_op(logic [7:0] op);
    @(negedge clk); op_valid = 1'b1; op_data = op;
    @(negedge clk); op_valid = 1'b0; op_data = 8'h00;
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); stop_wake = 1'b1;
    @(negedge clk); stop_wake = 1'b0;
  endtask

  initial begin
    cur_req = "R1";  idle(4);
    @(negedge clk); arst_n = 1'b1;
    cur_req = "R2";  idle(2);
    cur_req = "R3";  idle(25);
    cur_req = "R6";  send_op(8'hFF); send_op(8'h7F); idle(4);
    cur_req = "R9";  @(negedge clk); irq_pend = 4'b0100;
    @(negedge clk); irq_pend = '0; idle(2);
    cur_req = "R8";  send_op(8'h7F); send_op(8'hFF); send_op(8'h00);
    send_op(8'h6F); idle(3);
    cur_req = "R7";  send_op(8'hFF); send_op(8'h6F); idle(3);
    cur_req = "R10"; @(negedge clk); irq_pend = 4'b1111; idle(3);
    irq_pend = '0; idle(2);
    cur_req = "R5";  pulse_wdt(); idle(5);
    cur_req = "R4";  pulse_wdt(); idle(25);
    cur_req = "R11"; pulse_wake(); idle(3);
    send_op(8'hFF); send_op(8'h6F); wake_delay_en = 1'b1; idle(2);
    pulse_wake(); idle(25);
    send_op(8'hFF); send_op(8'h6F); wake_delay_en = 1'b0; idle(2);
    pulse_wake(); idle(5);
    wake_delay_en = 1'b1;
    cur_req = "R12"; send_op(8'hFF); send_op(8'h6F); idle(2);
    @(negedge clk); ext_rst_n = 1'b0; idle(6);
    @(negedge clk); ext_rst_n = 1'b1; idle(6);
    cur_req = "R2";  @(negedge clk); pwr_good = 1'b0; idle(6);
    @(negedge clk); pwr_good = 1'b1; idle(30);
    cur_req = "R6";  send_op(8'hFF); send_op(8'h7F); idle(2);
    cur_req = "R5";  pulse_wdt(); idle(25);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule